// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider Controller

This block steers an external prescaler that divides by 64 or by 65, so that the chain of prescaler plus controller divides the incoming frequency by 64·N + A. The prescaler output clocks the block directly. On each of its edges the block updates a modulus-select output and, once per complete division cycle, a single divided-output pulse. That pulse is the divided frequency handed on to a phase comparator.

Inside the block two down counters share the prescaler clock. The main counter sets the length of a cycle, which is N prescaler periods. The swallow counter sets how many of those periods use divide-by-65, which is A periods. When the swallow counter is exhausted it stops at zero. The main counter keeps running until it also reaches zero. Both counters then reload from the programmed values.

A two-state machine holds the modulus:
- ST_SWALLOW selects divide-by-65.
- ST_STEADY selects divide-by-64.

It has two transitions:
- HALT: ST_SWALLOW moves to ST_STEADY when the last swallowed period ends.
- RELOAD: on reset or at the end of a cycle, the machine enters ST_SWALLOW when the effective A is nonzero, and ST_STEADY otherwise.

Top module: `swallow_ctrl`

## Requirements
- R1: In every cycle the number of prescaler periods with `mod65`=1 (divide-by-65) and `mod65`=0 (divide-by-64) sums to a division of 64·N + A input cycles, where N and A are the effective values.
- R2: Within a cycle, `mod65` is 1 for exactly the first A periods and 0 for every later period until the cycle ends, because the swallow counter halts at zero.
- R3: `div_pulse` is 1 for exactly one prescaler period per cycle, the last period of the cycle. The next period starts a new cycle.
- R4: With A = 0, `mod65` stays 0 for the whole cycle and the division is 64·N.
- R5: When the programmed A is greater than or equal to the programmed N, `cfg_err` is 1 and A is treated as N−1. When A is less than N, `cfg_err` is 0.
- R6: A programmed N of 0 is treated as N = 1 and raises `cfg_err`. In that case `div_pulse` is 1 in every period and the division is 64.
- R7: A synchronous reset (`rst`=1 at a clock edge) loads both counters. The period after that edge is the first period of a cycle, with `mod65` = (effective A ≠ 0).
- R8: `n_prog`, `a_prog` and `cfg_err` are sampled or updated only at reset or at a reload. A change part-way through a cycle affects only the next cycle.
- R9: N is 12 bits wide (up to 4095) and A is 6 bits wide (up to 63). N = 4095 with A = 63 divides by 262143.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output, used as the block clock |
| rst | input | 1 | Synchronous reset, active high |
| n_prog | input | 12 | Programmed main count N |
| a_prog | input | 6 | Programmed swallow count A |
| mod65 | output | 1 | 1 selects prescaler divide-by-65, 0 selects divide-by-64 |
| div_pulse | output | 1 | One-period pulse in the last period of each cycle |
| cfg_err | output | 1 | Set when the most recently loaded N/A pair was out of range |

## Verification
A corrupted swallow count shows at the ports in the first cycle after the fault. The number of divide-by-65 periods before `mod65` falls is wrong, so the measured division moves away from 64·N + A by one or more input cycles per period. A main counter that skips or repeats a value moves `div_pulse` away from the N-th period, and that is visible at the first pulse. A machine that stays in or returns to ST_SWALLOW shows up as a second rising edge of `mod65` inside one cycle. Every cycle is measured period by period, so any of these faults appears within one division cycle.

// File: rtl/swc_pkg.sv
package swc_pkg;

    // Modulus state of the controller
    typedef enum logic [0:0] {
        ST_SWALLOW = 1'b0,  // prescaler set to divide-by-65
        ST_STEADY  = 1'b1   // prescaler set to divide-by-64
    } swc_state_t;

endpackage

// File: rtl/swc_cfg_sanitize.sv
// Turns the programmed pair into legal effective values and flags misuse.
module swc_cfg_sanitize #(
    parameter int N_W = 12,
    parameter int A_W = 6
) (
    input  logic [N_W-1:0] n_prog,
    input  logic [A_W-1:0] a_prog,
    output logic [N_W-1:0] n_reload,   // effective N minus one
    output logic [A_W-1:0] a_reload,   // effective A
    output logic           err_now
);
    localparam logic [N_W-1:0] ONE_N = {{(N_W-1){1'b0}}, 1'b1};

    logic [N_W-1:0] n_eff;
    logic [N_W-1:0] a_ext;
    logic [N_W-1:0] a_clip;

    always_comb begin
        n_eff   = (n_prog == '0) ? ONE_N : n_prog;
        a_ext   = N_W'(a_prog);
        err_now = (n_prog == '0) || (a_ext >= n_prog);
        a_clip  = (a_ext >= n_eff) ? (n_eff - ONE_N) : a_ext;
        n_reload = n_eff - ONE_N;
        a_reload = a_clip[A_W-1:0];
    end
endmodule

// File: rtl/swc_downcnt.sv
// Loadable down counter, shared by the main and swallow counters.
module swc_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         is_zero,
    output logic         is_one
);
    localparam logic [W-1:0] ONE_W = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - ONE_W;
    end

    assign is_zero = (cnt == '0);
    assign is_one  = (cnt == ONE_W);
endmodule

// File: rtl/swc_fsm.sv
// Two-state modulus machine: ST_SWALLOW -> ST_STEADY on HALT, either on RELOAD.
module swc_fsm
    import swc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic n_zero,       // last period of the cycle
    input  logic a_one,        // last swallowed period
    input  logic a_reload_nz,  // effective A nonzero
    output logic load,
    output logic a_dec,
    output logic n_dec,
    output logic mod65,
    output logic div_pulse
);
    swc_state_t state_q, state_d;

    always_comb begin
        load  = rst || n_zero;
        n_dec = !load;
        a_dec = !load && (state_q == ST_SWALLOW);
        state_d = state_q;
        if (load)
            state_d = a_reload_nz ? ST_SWALLOW : ST_STEADY;   // RELOAD
        else begin
            unique case (state_q)
                ST_SWALLOW: if (a_one) state_d = ST_STEADY;   // HALT
                ST_STEADY:  state_d = ST_STEADY;
                default:    state_d = ST_STEADY;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_SWALLOW: mod65 = 1'b1;
            ST_STEADY:  mod65 = 1'b0;
            default:    mod65 = 1'b0;
        endcase
        div_pulse = n_zero;
    end
endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl #(
    parameter int N_W = 12,
    parameter int A_W = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] n_prog,
    input  logic [A_W-1:0] a_prog,
    output logic           mod65,
    output logic           div_pulse,
    output logic           cfg_err
);
    logic [N_W-1:0] n_reload;
    logic [A_W-1:0] a_reload;
    logic           err_now;
    logic [N_W-1:0] n_cnt;
    logic [A_W-1:0] a_cnt;
    logic           n_zero, n_one, a_zero, a_one;
    logic           load, a_dec, n_dec;

    swc_cfg_sanitize #(.N_W(N_W), .A_W(A_W)) cfg_i (
        .n_prog(n_prog), .a_prog(a_prog),
        .n_reload(n_reload), .a_reload(a_reload), .err_now(err_now)
    );

    swc_downcnt #(.W(N_W)) ncnt_i (
        .clk(clk), .load(load), .load_val(n_reload), .dec(n_dec),
        .cnt(n_cnt), .is_zero(n_zero), .is_one(n_one)
    );

    swc_downcnt #(.W(A_W)) acnt_i (
        .clk(clk), .load(load), .load_val(a_reload), .dec(a_dec),
        .cnt(a_cnt), .is_zero(a_zero), .is_one(a_one)
    );

    swc_fsm fsm_i (
        .clk(clk), .rst(rst), .n_zero(n_zero), .a_one(a_one),
        .a_reload_nz(a_reload != '0), .load(load), .a_dec(a_dec),
        .n_dec(n_dec), .mod65(mod65), .div_pulse(div_pulse)
    );

    // Error flag follows the pair captured at each load
    always_ff @(posedge clk) begin
        if (load) cfg_err <= err_now;
    end
endmodule

// File: rtl/swallow_ctrl_chk.sv
module swallow_ctrl_chk #(
    parameter int N_W = 12,
    parameter int A_W = 6
) (
    input logic           clk,
    input logic           rst,
    input logic           mod65,
    input logic           div_pulse,
    input logic [N_W-1:0] n_cnt,
    input logic [A_W-1:0] a_cnt,
    input logic [N_W-1:0] n_reload
);
    assert_a_within_n_R5: assert property (@(posedge clk) disable iff (rst)
        N_W'(a_cnt) <= n_cnt);

    assert_swallow_needs_a_R2: assert property (@(posedge clk) disable iff (rst)
        mod65 |-> (a_cnt != '0));

    assert_halt_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (!mod65 && !div_pulse) |=> !mod65);

    assert_reload_on_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> (n_cnt == $past(n_reload)));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (div_pulse && n_reload != '0) |=> !div_pulse);
endmodule

bind swallow_ctrl swallow_ctrl_chk #(.N_W(N_W), .A_W(A_W)) chk_i (
    .clk(clk), .rst(rst), .mod65(mod65), .div_pulse(div_pulse),
    .n_cnt(n_cnt), .a_cnt(a_cnt), .n_reload(n_reload)
);

// File: tb/swallow_ctrl_tb_top.sv
`timescale 1ns/1ps
module swallow_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] n_prog = 12'd1;
    logic [5:0]  a_prog = 6'd0;
    logic        mod65, div_pulse, cfg_err;
    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    swallow_ctrl dut_i (
        .clk(clk), .rst(rst), .n_prog(n_prog), .a_prog(a_prog),
        .mod65(mod65), .div_pulse(div_pulse), .cfg_err(cfg_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int eff_n(int n);
        return (n == 0) ? 1 : n;
    endfunction
    function automatic int eff_a(int n, int a);
        return (a >= eff_n(n)) ? eff_n(n) - 1 : a;
    endfunction
    function automatic int eff_err(int n, int a);
        return (n == 0 || a >= n) ? 1 : 0;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Called at the negedge inside period 0 of a cycle; returns at period 0 of the next.
    task automatic measure(int ne, int ae, string req);
        int div = 0;
        int swallowed = 0;
        int pat_bad = 0;
        int pulse_bad = 0;
        for (int k = 0; k < ne; k++) begin
            div += mod65 ? 65 : 64;
            if (mod65) swallowed++;
            if (mod65 != (k < ae)) pat_bad++;
            if (div_pulse != (k == ne - 1)) pulse_bad++;
            @(negedge clk);
        end
        chk(div == 64 * ne + ae, {req, "/R1 division"}, div, 64 * ne + ae);
        chk(pat_bad == 0 && swallowed == ae, {req, "/R2 swallow pattern"}, swallowed, ae);
        chk(pulse_bad == 0, {req, "/R3 pulse position"}, pulse_bad, 0);
    endtask

    task automatic do_reset(int n, int a);
        @(negedge clk);
        n_prog = 12'(n);
        a_prog = 6'(a);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        // now inside period 0 (R7)
        chk(mod65 == (eff_a(n, a) != 0), "R7 reset modulus", int'(mod65), int'(eff_a(n, a) != 0));
        chk(div_pulse == (eff_n(n) == 1), "R7 reset pulse", int'(div_pulse), int'(eff_n(n) == 1));
        chk(cfg_err == eff_err(n, a), "R5 error flag", int'(cfg_err), eff_err(n, a));
    endtask

    task automatic run_cfg(int n, int a, int cycles, string req);
        do_reset(n, a);
        for (int c = 0; c < cycles; c++) measure(eff_n(n), eff_a(n, a), req);
    endtask

    initial begin
        void'($urandom(32'd7719));
        repeat (3) @(negedge clk);
        // Directed corners
        run_cfg(27, 22, 2, "R1 N27A22");
        chk(64 * 27 + 22 == 1750, "R1 reference 1750", 64 * 27 + 22, 1750);
        run_cfg(10, 0, 2, "R4 A0");
        run_cfg(5, 9, 2, "R5 A>N");
        run_cfg(6, 6, 2, "R5 A=N");
        run_cfg(0, 3, 3, "R6 N0");
        run_cfg(1, 0, 3, "R3 N1");
        run_cfg(4095, 63, 1, "R9 max");
        chk(64 * 4095 + 63 == 262143, "R9 max division", 64 * 4095 + 63, 262143);

        // R8: change the pair during the first cycle
        do_reset(12, 5);
        n_prog = 12'd3;
        a_prog = 6'd7;
        measure(12, 5, "R8 old pair");
        chk(cfg_err == 1'b1, "R8 error at next load", int'(cfg_err), 1);
        measure(3, 2, "R8 new pair");

        // Random configurations
        for (int i = 0; i < 25; i++) begin
            int n = int'($urandom_range(0, 160));
            int a = int'($urandom_range(0, 63));
            run_cfg(n, a, 2, "R1 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule